// File: doc/BRIEF.md
# Deferred Copyback Line Buffer

This block sits beside a write-back data cache and holds one dirty line that the replacement logic has evicted. The line is the line address plus four data words. The victim selector loads it in one cycle. The buffer then waits until the cache reports that the replacing line fill has finished. Only after that does it stream the held line to memory as a single four-beat write burst. This keeps the critical fill ahead of the write-back on the bus.

While the burst is pending or in flight, cache requests that hit are never held back. A request that misses needs the buffer, so it is stalled until the buffer empties. If the bus acknowledges a beat with an error, the burst stops there. The block then raises a one-cycle machine-check pulse, which is imprecise because it is not tied to the access that is currently executing. The held address and words stay in place after the burst completes or fails. Software can read them through a registered debug port until the next line is loaded.

Top module: `copyback_buffer`

## Requirements
- R1: During and right after reset, `busy`, `wr_valid`, `req_stall`, `mchk_pulse` and `dbg_rvalid` are all 0, and every held address and data bit is 0.
- R2: When the buffer is empty, `ld_valid` captures `ld_addr` and `ld_data` (word k is `ld_data[32k+31:32k]`), and `busy` is 1 from the next cycle. While `busy` is 1, `ld_valid` is ignored and the held line does not change.
- R3: No beat is presented until `fill_done` is seen while a line is held. A `fill_done` that arrives while the buffer is empty has no effect.
- R4: The burst starts the cycle after `fill_done`. It has four beats k = 0,1,2,3 in that order. Beat k carries `wr_addr = {line, k[1:0]}` and word k. `wr_last` is 1 only on beat 3. Each beat is held unchanged until `wr_ack` is 1 on a clock edge.
- R5: After beat 3 is acknowledged without error, `busy` and `wr_valid` are 0 from the next cycle.
- R6: `req_stall` is 1 in the same cycle exactly when `req_valid` is 1, `req_hit` is 0 and `busy` is 1. A request with `req_hit` = 1 is never stalled.
- R7: A beat acknowledged with `wr_err` = 1 ends the burst. In the next cycle, `busy` and `wr_valid` are 0 and `mchk_pulse` is 1 for exactly one cycle. No further beats of that line are presented.
- R8: `dbg_rd` with `dbg_sel` returns data one cycle later with `dbg_rvalid` = 1. Select 0 returns the line address zero-extended to 32 bits, select k (1..4) returns word k-1, and any other select returns 0. The held contents survive the end of a burst, whether it completed or failed.
- R9: Once `busy` has cleared, a new `ld_valid` is accepted and replaces the held line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Victim line load strobe |
| ld_addr | input | 28 | Line address of the victim |
| ld_data | input | 128 | Four victim words, word k at bits 32k+31:32k |
| fill_done | input | 1 | Replacing line fill has finished |
| req_valid | input | 1 | Cache request present |
| req_hit | input | 1 | That request hits in the cache |
| req_stall | output | 1 | Hold the missing request |
| wr_valid | output | 1 | Write beat presented |
| wr_addr | output | 30 | Word address of the beat |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of the burst |
| wr_ack | input | 1 | Beat accepted by the bus |
| wr_err | input | 1 | Bus error on the accepted beat |
| busy | output | 1 | A line is held |
| mchk_pulse | output | 1 | Imprecise machine-check strobe |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_sel | input | 3 | Debug select: 0 address, 1..4 words |
| dbg_rvalid | output | 1 | Debug data valid |
| dbg_rdata | output | 32 | Debug read data |

## Verification
`req_stall` and every write-beat field depend on the current inputs and state within the same cycle. `busy`, the first beat, the end of a burst and `mchk_pulse` appear one clock edge after the load, `fill_done` or acknowledge that causes them. Debug data appears one edge after `dbg_rd`. The bench drives inputs just after each rising edge and advances its reference model on that edge. It compares every output at the falling edge, so each comparison sees exactly one register stage past the stimulus. The acknowledge pattern, error beat and debug reads are varied so that every one of these delays is exercised.

// File: rtl/cbuf_pkg.sv
// Shared types for the deferred copyback buffer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package cbuf_pkg;
    typedef enum logic [1:0] {
        CB_EMPTY = 2'd0,
        CB_HELD  = 2'd1,
        CB_WRITE = 2'd2
    } cb_state_t;
endpackage

// File: rtl/cbuf_ctrl.sv
// Sequencing for the copyback buffer: empty -> held -> writing.
// Assumes WORDS is a power of two and that wr_err is only meaningful with wr_ack.
module cbuf_ctrl
    import cbuf_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int BW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          fill_done,
    input  logic          req_valid,
    input  logic          req_hit,
    input  logic          wr_ack,
    input  logic          wr_err,
    output logic          load_en,
    output logic          busy,
    output logic          wr_valid,
    output logic          wr_last,
    output logic          req_stall,
    output logic          mchk_pulse,
    output logic [BW-1:0] beat
);
    localparam logic [BW-1:0] LAST_BEAT = BW'(WORDS - 1);

    cb_state_t state_q;

    // State, beat counter and error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CB_EMPTY;
            beat       <= '0;
            mchk_pulse <= 1'b0;
        end else begin
            mchk_pulse <= 1'b0;
            case (state_q)
                CB_EMPTY: if (ld_valid) state_q <= CB_HELD;
                CB_HELD: begin
                    if (fill_done) begin
                        state_q <= CB_WRITE;
                        beat    <= '0;
                    end
                end
                CB_WRITE: begin
                    if (wr_ack) begin
                        if (wr_err) begin
                            state_q    <= CB_EMPTY;
                            mchk_pulse <= 1'b1;
                        end else if (beat == LAST_BEAT) begin
                            state_q <= CB_EMPTY;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state_q <= CB_EMPTY;
            endcase
        end
    end

    // Status decode and miss stall.
    always_comb begin
        load_en   = (state_q == CB_EMPTY) && ld_valid;
        busy      = (state_q != CB_EMPTY);
        wr_valid  = (state_q == CB_WRITE);
        wr_last   = wr_valid && (beat == LAST_BEAT);
        req_stall = req_valid && !req_hit && busy;
    end
endmodule

// File: rtl/cbuf_store.sv
// Line storage for the copyback buffer plus the registered debug read port.
// Assumes AW <= DW so the line address fits one debug word.
module cbuf_store #(
    parameter int AW    = 28,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int BW = $clog2(WORDS),
    localparam int SW = $clog2(WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [AW-1:0]       ld_addr,
    input  logic [WORDS*DW-1:0] ld_data,
    input  logic [BW-1:0]       beat,
    input  logic                dbg_rd,
    input  logic [SW-1:0]       dbg_sel,
    output logic [AW+BW-1:0]    wr_addr,
    output logic [DW-1:0]       wr_data,
    output logic                dbg_rvalid,
    output logic [DW-1:0]       dbg_rdata
);
    logic [AW-1:0] line_q;
    logic [DW-1:0] word_q [WORDS];
    logic [DW-1:0] dbg_next;

    // Line address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       line_q <= '0;
        else if (load_en) line_q <= ld_addr;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // One held data word.
        always_ff @(posedge clk) begin
            if (!rst_n)       word_q[g] <= '0;
            else if (load_en) word_q[g] <= ld_data[g*DW +: DW];
        end
    end

    // Beat address and data.
    always_comb begin
        wr_addr = {line_q, beat};
        wr_data = word_q[beat];
    end

    // Debug select decode.
    always_comb begin
        dbg_next = '0;
        if (dbg_sel == '0) begin
            dbg_next[AW-1:0] = line_q;
        end else if (int'(dbg_sel) <= WORDS) begin
            dbg_next = word_q[BW'(int'(dbg_sel) - 1)];
        end
    end

    // Registered debug response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_rvalid <= 1'b0;
            dbg_rdata  <= '0;
        end else begin
            dbg_rvalid <= dbg_rd;
            if (dbg_rd) dbg_rdata <= dbg_next;
        end
    end
endmodule

// File: rtl/copyback_buffer.sv
// Deferred copyback buffer: holds one evicted line and writes it out as a
// burst once the replacing fill is done; misses stall while it is busy.
// Assumes the victim selector only loads dirty lines.
module copyback_buffer #(
    parameter int AW    = 28,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int BW = $clog2(WORDS),
    localparam int SW = $clog2(WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_valid,
    input  logic [AW-1:0]       ld_addr,
    input  logic [WORDS*DW-1:0] ld_data,
    input  logic                fill_done,
    input  logic                req_valid,
    input  logic                req_hit,
    output logic                req_stall,
    output logic                wr_valid,
    output logic [AW+BW-1:0]    wr_addr,
    output logic [DW-1:0]       wr_data,
    output logic                wr_last,
    input  logic                wr_ack,
    input  logic                wr_err,
    output logic                busy,
    output logic                mchk_pulse,
    input  logic                dbg_rd,
    input  logic [SW-1:0]       dbg_sel,
    output logic                dbg_rvalid,
    output logic [DW-1:0]       dbg_rdata
);
    logic          load_en;
    logic [BW-1:0] beat;

    cbuf_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .fill_done  (fill_done),
        .req_valid  (req_valid),
        .req_hit    (req_hit),
        .wr_ack     (wr_ack),
        .wr_err     (wr_err),
        .load_en    (load_en),
        .busy       (busy),
        .wr_valid   (wr_valid),
        .wr_last    (wr_last),
        .req_stall  (req_stall),
        .mchk_pulse (mchk_pulse),
        .beat       (beat)
    );

    cbuf_store #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .beat       (beat),
        .dbg_rd     (dbg_rd),
        .dbg_sel    (dbg_sel),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dbg_rvalid (dbg_rvalid),
        .dbg_rdata  (dbg_rdata)
    );
endmodule

// File: rtl/copyback_buffer_chk.sv
// Port-level temporal checks for the copyback buffer, bound to every instance.
module copyback_buffer_chk #(
    parameter int AW    = 28,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int BW = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic             fill_done,
    input logic             req_valid,
    input logic             req_hit,
    input logic             req_stall,
    input logic             wr_valid,
    input logic [AW+BW-1:0] wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic             wr_last,
    input logic             wr_ack,
    input logic             wr_err,
    input logic             busy,
    input logic             mchk_pulse,
    input logic             dbg_rd,
    input logic             dbg_rvalid
);
    p_load_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ld_valid) |=> busy);
    p_write_needs_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !fill_done) |=> !wr_valid);
    p_beat_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ack && wr_last && !wr_err) |=> (!busy && !wr_valid && !mchk_pulse));
    p_hit_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit) |-> !req_stall);
    p_err_mchk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ack && wr_err) |=> (mchk_pulse && !busy && !wr_valid));
    p_mchk_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_pulse |=> !mchk_pulse);
    p_dbg_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rd |=> dbg_rvalid);
    p_write_implies_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);
endmodule

bind copyback_buffer copyback_buffer_chk #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .fill_done  (fill_done),
    .req_valid  (req_valid),
    .req_hit    (req_hit),
    .req_stall  (req_stall),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_last    (wr_last),
    .wr_ack     (wr_ack),
    .wr_err     (wr_err),
    .busy       (busy),
    .mchk_pulse (mchk_pulse),
    .dbg_rd     (dbg_rd),
    .dbg_rvalid (dbg_rvalid)
);

// File: tb/copyback_buffer_tb.sv
// Bench: behavioural reference model advanced on each rising edge,
// all outputs compared at every falling edge.
module copyback_buffer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic [27:0]  ld_addr = '0;
    logic [127:0] ld_data = '0;
    logic         fill_done = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_hit = 1'b0;
    logic         req_stall;
    logic         wr_valid;
    logic [29:0]  wr_addr;
    logic [31:0]  wr_data;
    logic         wr_last;
    logic         wr_ack = 1'b0;
    logic         wr_err = 1'b0;
    logic         busy;
    logic         mchk_pulse;
    logic         dbg_rd = 1'b0;
    logic [2:0]   dbg_sel = '0;
    logic         dbg_rvalid;
    logic [31:0]  dbg_rdata;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int ack_div = 1;
    int err_at = -1;
    int acked = 0;
    bit seen_edge = 0;
    bit done = 0;

    // reference model state
    int          m_state = 0;
    int          m_beat = 0;
    logic [27:0] m_line = '0;
    logic [31:0] m_words [4] = '{default: '0};
    bit          m_mchk = 0;
    bit          m_rv = 0;
    logic [31:0] m_rd = '0;

    copyback_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .fill_done(fill_done), .req_valid(req_valid),
        .req_hit(req_hit), .req_stall(req_stall), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
        .wr_ack(wr_ack), .wr_err(wr_err), .busy(busy), .mchk_pulse(mchk_pulse),
        .dbg_rd(dbg_rd), .dbg_sel(dbg_sel), .dbg_rvalid(dbg_rvalid),
        .dbg_rdata(dbg_rdata)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        cyc++;
        seen_edge = 1;
        if (!rst_n) begin
            m_state = 0; m_beat = 0; m_line = '0; m_mchk = 0; m_rv = 0; m_rd = '0;
            for (int i = 0; i < 4; i++) m_words[i] = '0;
        end else begin
            m_rv = dbg_rd;
            if (dbg_rd) begin
                if (dbg_sel == 0) m_rd = {4'h0, m_line};
                else if (dbg_sel <= 4) m_rd = m_words[dbg_sel - 1];
                else m_rd = '0;
            end
            m_mchk = 0;
            case (m_state)
                0: if (ld_valid) begin
                    m_line = ld_addr;
                    for (int i = 0; i < 4; i++) m_words[i] = ld_data[i*32 +: 32];
                    m_state = 1;
                end
                1: if (fill_done) begin m_state = 2; m_beat = 0; end
                default: if (wr_ack) begin
                    if (wr_err) begin m_state = 0; m_mchk = 1; end
                    else if (m_beat == 3) m_state = 0;
                    else m_beat++;
                end
            endcase
        end
    end

    // Bus acknowledge driver.
    always @(posedge clk) begin
        #1;
        wr_ack = 1'b0;
        wr_err = 1'b0;
        if (!wr_valid) acked = 0;
        else if ((cyc % ack_div) == 0) begin
            wr_ack = 1'b1;
            wr_err = (acked == err_at);
            acked++;
        end
    end

    // Compare all outputs at the falling edge.
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            if (!rst_n) begin
                check("R1 reset outputs", {busy, wr_valid, req_stall, mchk_pulse, dbg_rvalid}, 5'b0);
            end else begin
                check("R2/R5/R9 busy", busy, m_state != 0);
                check("R3/R4 wr_valid", wr_valid, m_state == 2);
                if (m_state == 2) begin
                    check("R4 wr_addr", wr_addr, {m_line, 2'(m_beat)});
                    check("R4 wr_data", wr_data, m_words[m_beat]);
                    check("R4 wr_last", wr_last, m_beat == 3);
                end
                check("R6 req_stall", req_stall, req_valid && !req_hit && (m_state != 0));
                check("R7 mchk_pulse", mchk_pulse, m_mchk);
                check("R8 dbg_rvalid", dbg_rvalid, m_rv);
                if (m_rv) check("R8 dbg_rdata", dbg_rdata, m_rd);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic load(input logic [27:0] a, input logic [127:0] d);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        step(1);
        ld_valid = 1'b0; ld_addr = '0; ld_data = '0;
    endtask

    task automatic pulse_fill();
        fill_done = 1'b1; step(1); fill_done = 1'b0;
    endtask

    task automatic dbg_all();
        for (int s = 0; s < 7; s++) begin
            dbg_rd = 1'b1; dbg_sel = 3'(s); step(1);
        end
        dbg_rd = 1'b0; dbg_sel = '0;
    endtask

    task automatic reqs();
        req_valid = 1'b1; req_hit = 1'b1; step(1);
        req_hit = 1'b0; step(1);
        req_valid = 1'b0; step(1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) step(1);
    endtask

    // Watchdog.
    initial begin
        #40000;
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog expired (actual hung, expected completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        step(3);                       // R1 reset observed
        rst_n = 1'b1;
        step(1);
        dbg_all();                     // R1: held contents read back as zero
        pulse_fill();                  // R3: fill while empty ignored
        step(2);
        reqs();                        // R6: idle, no stall
        load(28'h1234567, 128'hDDDD0004_CCCC0003_BBBB0002_AAAA0001);   // R2
        reqs();                        // R6: miss stalls while held
        load(28'h0FFFFFF, {4{32'hDEADBEEF}});                          // R2: ignored
        step(3);                       // R3: no write without fill
        dbg_all();
        ack_div = 3; err_at = -1;
        pulse_fill();                  // R4 with slow acknowledge
        req_valid = 1'b1; req_hit = 1'b1; step(2);
        req_hit = 1'b0; step(2); req_valid = 1'b0;
        wait_idle();                   // R5
        step(2);
        dbg_all();                     // R8: retained after completion
        ack_div = 1; err_at = 2;
        load(28'hABCDEF0, 128'h44444444_33333333_22222222_11111111);   // R9
        step(1);
        pulse_fill();                  // R7: error on beat 2
        wait_idle();
        step(3);
        dbg_all();                     // R8: retained after error
        err_at = 0;
        load(28'h0000001, 128'h0);
        fill_done = 1'b1; step(1);     // fill held high across write
        wait_idle();
        fill_done = 1'b0;
        step(2);
        err_at = -1; ack_div = 2;
        load(28'h7777777, 128'h89ABCDEF_01234567_FEDCBA98_76543210);
        dbg_rd = 1'b1; dbg_sel = 3'd3; pulse_fill(); dbg_rd = 1'b0;
        wait_idle();
        step(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule